// File: doc/BRIEF.md
# Miss-status register file with evicted-upgrade recovery

This block holds a small set of miss-status entries for a write-back cache. Each entry records one outstanding miss or ownership upgrade by line address. An upgrade is a request for exclusive ownership of a line that is already held shared. Allocation takes the lowest free entry. The entry is released when its response has been handled.

The block also covers one corner case. A line with an upgrade in flight can be chosen as a victim by another fill before the upgrade answer returns. The cache announces every victim as a replacement of eight 64-bit beats, holding the victim address on all of them. The block compares that address against all valid entries in the same cycle and marks the matching entry.

- If the victim was dirty, the normal writeback carries the data away. A later upgrade answer for a line that is no longer cached then produces a one-cycle reissue request for an exclusive read.
- If the victim was clean, the block keeps the eight beats. The later answer is turned into an exclusive-read response that streams the saved line back, beat by beat, so the cache can refill it.

Top module: `mshr_file`

## Requirements
- R1: While rst_ni is low and after its release, every entry is free: full_o is 0, alloc_id_o is 0, and reissue_valid_o and xresp_valid_o are 0.
- R2: A cycle with alloc_valid_i high and full_o low takes the lowest-numbered free entry, shown on alloc_id_o in that cycle. full_o is 1 exactly when every entry is busy, and a request while full is ignored.
- R3: repl_hit_o is 1 in the same cycle as repl_valid_i whenever repl_addr_i[31:6] equals the line address of a valid entry. On beat 0 of a replacement, a hit on an entry holding an exclusive request, with repl_writable_i low, marks that entry as replaced and records repl_dirty_i. If repl_dirty_i is low, beat k of repl_data_i (k = 0..7, counted over consecutive repl_valid_i cycles) is saved as beat k of that entry.
- R4: A replacement whose address matches no valid entry changes no entry state and produces no output.
- R5: An upgrade answer (upg_valid_i) with upg_present_i low, for an entry whose replacement was dirty, raises reissue_valid_o for exactly the next cycle. reissue_id_o carries the entry index and reissue_addr_o the line address with bits [5:0] zero. The entry stays busy.
- R6: The same answer for an entry whose replacement was clean raises xresp_valid_o for the next eight cycles. xresp_beat_o runs 0..7, xresp_data_o is the saved beat of that index, xresp_last_o is high on beat 7, and xresp_id_o and xresp_addr_o name the entry. The entry is free in the cycle after beat 7.
- R7: An upgrade answer with upg_present_i high frees the entry, and neither reissue_valid_o nor xresp_valid_o follows.
- R8: Allocation clears an entry's replaced mark, dirty mark and saved line. Earlier recovery state never leaks into the entry's new request.
- R9: done_valid_i frees entry done_id_i, and that entry is free from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocate an entry this cycle |
| alloc_addr_i | input | 32 | Byte address of the new request |
| alloc_excl_i | input | 1 | New request asks for exclusive ownership |
| alloc_id_o | output | 2 | Index that an allocation takes this cycle |
| full_o | output | 1 | All entries busy |
| repl_valid_i | input | 1 | One beat of a victim notification |
| repl_addr_i | input | 32 | Victim byte address, held for all beats |
| repl_dirty_i | input | 1 | Victim line is dirty |
| repl_writable_i | input | 1 | Victim line is already writable |
| repl_data_i | input | 64 | Victim line data beat |
| repl_hit_o | output | 1 | Victim address matches a valid entry |
| upg_valid_i | input | 1 | Upgrade answer arrives |
| upg_id_i | input | 2 | Entry the answer belongs to |
| upg_present_i | input | 1 | Line is still present in the cache |
| done_valid_i | input | 1 | Response for an entry fully handled |
| done_id_i | input | 2 | Entry to free |
| reissue_valid_o | output | 1 | Reissue the entry as an exclusive read |
| reissue_id_o | output | 2 | Entry to reissue |
| reissue_addr_o | output | 32 | Line address to reissue |
| xresp_valid_o | output | 1 | Synthesized exclusive-read response beat |
| xresp_id_o | output | 2 | Entry whose saved line is streamed |
| xresp_beat_o | output | 3 | Beat index within the line |
| xresp_last_o | output | 1 | Final beat |
| xresp_addr_o | output | 32 | Line address of the response |
| xresp_data_o | output | 64 | Saved line data beat |

## Verification
The checks assume well-behaved neighbours:
- A victim that hits an entry always belongs to an exclusive request and is never already writable.
- An upgrade answer that finds its line gone always names an entry that was marked as replaced.
- Done and upgrade events target busy entries, never one whose saved line is being streamed out.
- Replacement beats arrive as an unbroken group of eight.

The stimulus keeps to all of this by construction. Exclusive entries are the only victims that match, and every upgrade answer follows the replacement it depends on. No new event is driven until a streamed response has finished. The non-exclusive entry is never named as a victim.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned LINE_BYTES = 64;
  localparam int unsigned BEAT_W     = 64;
  localparam int unsigned BEATS      = LINE_BYTES * 8 / BEAT_W;
  localparam int unsigned OFF_W      = $clog2(LINE_BYTES);
  localparam int unsigned LADDR_W    = ADDR_W - OFF_W;
  localparam int unsigned BIDX_W     = $clog2(BEATS);

  typedef logic [LADDR_W-1:0] laddr_t;
  typedef logic [BEAT_W-1:0]  beat_t;
  typedef logic [BIDX_W-1:0]  bidx_t;
endpackage

// File: rtl/mshr_pick_free.sv
module mshr_pick_free #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     busy_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mshr_match.sv
module mshr_match import mshr_pkg::*; #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]         valid_i,
  input  laddr_t [N-1:0]       laddr_i,
  input  laddr_t               key_i,
  output logic                 hit_o,
  output logic [IDX_W-1:0]     idx_o
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = valid_i[g] && (laddr_i[g] == key_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |eq;
endmodule

// File: rtl/mshr_entry.sv
module mshr_entry import mshr_pkg::*; (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   alloc_i,
  input  laddr_t alloc_laddr_i,
  input  logic   alloc_excl_i,
  input  logic   dealloc_i,
  input  logic   mark_repl_i,
  input  logic   mark_dirty_i,
  input  logic   clr_repl_i,
  input  logic   wr_i,
  input  bidx_t  wr_beat_i,
  input  beat_t  wr_data_i,
  input  bidx_t  rd_beat_i,
  output logic   valid_o,
  output laddr_t laddr_o,
  output logic   excl_o,
  output logic   repl_o,
  output logic   dirty_o,
  output logic   bufv_o,
  output beat_t  rd_data_o
);
  beat_t buf_q [BEATS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      laddr_o <= '0;
      excl_o  <= 1'b0;
      repl_o  <= 1'b0;
      dirty_o <= 1'b0;
      bufv_o  <= 1'b0;
    end else if (alloc_i) begin
      valid_o <= 1'b1;
      laddr_o <= alloc_laddr_i;
      excl_o  <= alloc_excl_i;
      repl_o  <= 1'b0;
      dirty_o <= 1'b0;
      bufv_o  <= 1'b0;
    end else if (dealloc_i) begin
      valid_o <= 1'b0;
      repl_o  <= 1'b0;
      bufv_o  <= 1'b0;
    end else begin
      if (mark_repl_i) begin
        repl_o  <= 1'b1;
        dirty_o <= mark_dirty_i;
        bufv_o  <= 1'b0;
      end else if (clr_repl_i) begin
        repl_o <= 1'b0;
      end
      if (wr_i && wr_beat_i == bidx_t'(BEATS - 1)) bufv_o <= 1'b1;
    end
  end

  // line buffer needs no reset: bufv_o qualifies it
  always_ff @(posedge clk_i) begin
    if (wr_i) buf_q[wr_beat_i] <= wr_data_i;
  end

  assign rd_data_o = buf_q[rd_beat_i];
endmodule

// File: rtl/mshr_fill_seq.sv
module mshr_fill_seq import mshr_pkg::*; #(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] start_id_i,
  output logic             active_o,
  output logic [IDX_W-1:0] id_o,
  output bidx_t            beat_o,
  output logic             last_o
);
  assign last_o = active_o && (beat_o == bidx_t'(BEATS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      id_o     <= '0;
      beat_o   <= '0;
    end else if (start_i && !active_o) begin
      active_o <= 1'b1;
      id_o     <= start_id_i;
      beat_o   <= '0;
    end else if (active_o) begin
      beat_o <= beat_o + 1'b1;
      if (last_o) active_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file import mshr_pkg::*; #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               alloc_valid_i,
  input  logic [ADDR_W-1:0]  alloc_addr_i,
  input  logic               alloc_excl_i,
  output logic [IDX_W-1:0]   alloc_id_o,
  output logic               full_o,
  input  logic               repl_valid_i,
  input  logic [ADDR_W-1:0]  repl_addr_i,
  input  logic               repl_dirty_i,
  input  logic               repl_writable_i,
  input  logic [BEAT_W-1:0]  repl_data_i,
  output logic               repl_hit_o,
  input  logic               upg_valid_i,
  input  logic [IDX_W-1:0]   upg_id_i,
  input  logic               upg_present_i,
  input  logic               done_valid_i,
  input  logic [IDX_W-1:0]   done_id_i,
  output logic               reissue_valid_o,
  output logic [IDX_W-1:0]   reissue_id_o,
  output logic [ADDR_W-1:0]  reissue_addr_o,
  output logic               xresp_valid_o,
  output logic [IDX_W-1:0]   xresp_id_o,
  output logic [BIDX_W-1:0]  xresp_beat_o,
  output logic               xresp_last_o,
  output logic [ADDR_W-1:0]  xresp_addr_o,
  output logic [BEAT_W-1:0]  xresp_data_o
);
  logic [N-1:0]     ent_valid, ent_excl, ent_repl, ent_dirty, ent_bufv;
  laddr_t [N-1:0]   ent_laddr;
  beat_t            ent_rd [N];
  logic [IDX_W-1:0] free_idx, match_idx;
  logic             any_free, match_hit;
  bidx_t            repl_beat_q;
  logic             repl_take, repl_first, fill_start, fill_done;
  logic             reissue_q;
  logic [IDX_W-1:0] reissue_id_q;
  logic             unused_off;

  assign unused_off = ^{alloc_addr_i[OFF_W-1:0], repl_addr_i[OFF_W-1:0]};

  mshr_pick_free #(.N(N), .IDX_W(IDX_W)) u_free (
    .busy_i (ent_valid),
    .idx_o  (free_idx),
    .any_o  (any_free)
  );

  mshr_match #(.N(N), .IDX_W(IDX_W)) u_match (
    .valid_i (ent_valid),
    .laddr_i (ent_laddr),
    .key_i   (repl_addr_i[ADDR_W-1:OFF_W]),
    .hit_o   (match_hit),
    .idx_o   (match_idx)
  );

  assign alloc_id_o = free_idx;
  assign full_o     = !any_free;
  assign repl_hit_o = repl_valid_i && match_hit;
  assign repl_first = (repl_beat_q == '0);
  // only an exclusive request on a read-only victim is recoverable
  assign repl_take  = repl_hit_o && ent_excl[match_idx] && !repl_writable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) repl_beat_q <= '0;
    else if (repl_valid_i) repl_beat_q <= repl_beat_q + 1'b1;
  end

  assign fill_start = upg_valid_i && !upg_present_i && !ent_dirty[upg_id_i];

  mshr_fill_seq #(.IDX_W(IDX_W)) u_fill (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (fill_start),
    .start_id_i (upg_id_i),
    .active_o   (xresp_valid_o),
    .id_o       (xresp_id_o),
    .beat_o     (xresp_beat_o),
    .last_o     (xresp_last_o)
  );

  assign fill_done = xresp_last_o;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic sel_upg, sel_done, sel_fill, sel_repl;
    assign sel_upg  = upg_valid_i && upg_id_i == IDX_W'(g);
    assign sel_done = done_valid_i && done_id_i == IDX_W'(g);
    assign sel_fill = fill_done && xresp_id_o == IDX_W'(g);
    assign sel_repl = repl_take && match_idx == IDX_W'(g);

    mshr_entry u_ent (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .alloc_i       (alloc_valid_i && any_free && free_idx == IDX_W'(g)),
      .alloc_laddr_i (alloc_addr_i[ADDR_W-1:OFF_W]),
      .alloc_excl_i  (alloc_excl_i),
      .dealloc_i     ((sel_upg && upg_present_i) || sel_done || sel_fill),
      .mark_repl_i   (sel_repl && repl_first),
      .mark_dirty_i  (repl_dirty_i),
      .clr_repl_i    (sel_upg && !upg_present_i),
      .wr_i          (sel_repl && !repl_dirty_i),
      .wr_beat_i     (repl_beat_q),
      .wr_data_i     (repl_data_i),
      .rd_beat_i     (xresp_beat_o),
      .valid_o       (ent_valid[g]),
      .laddr_o       (ent_laddr[g]),
      .excl_o        (ent_excl[g]),
      .repl_o        (ent_repl[g]),
      .dirty_o       (ent_dirty[g]),
      .bufv_o        (ent_bufv[g]),
      .rd_data_o     (ent_rd[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reissue_q    <= 1'b0;
      reissue_id_q <= '0;
    end else begin
      reissue_q    <= upg_valid_i && !upg_present_i && ent_dirty[upg_id_i];
      reissue_id_q <= upg_id_i;
    end
  end

  assign reissue_valid_o = reissue_q;
  assign reissue_id_o    = reissue_id_q;
  assign reissue_addr_o  = {ent_laddr[reissue_id_q], {OFF_W{1'b0}}};
  assign xresp_addr_o    = {ent_laddr[xresp_id_o], {OFF_W{1'b0}}};
  assign xresp_data_o    = ent_rd[xresp_id_o];
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             alloc_valid_i,
  input logic [IDX_W-1:0] alloc_id_o,
  input logic             full_o,
  input logic             repl_valid_i,
  input logic             repl_writable_i,
  input logic             repl_hit_o,
  input logic             upg_valid_i,
  input logic [IDX_W-1:0] upg_id_i,
  input logic             upg_present_i,
  input logic             done_valid_i,
  input logic [IDX_W-1:0] done_id_i,
  input logic             reissue_valid_o,
  input logic [IDX_W-1:0] reissue_id_o,
  input logic             xresp_valid_o,
  input logic [IDX_W-1:0] xresp_id_o,
  input logic [2:0]       xresp_beat_o,
  input logic             xresp_last_o,
  input logic [N-1:0]     valid_vec,
  input logic [N-1:0]     excl_vec,
  input logic [N-1:0]     repl_vec,
  input logic [N-1:0]     dirty_vec,
  input logic [N-1:0]     bufv_vec,
  input logic [IDX_W-1:0] match_idx
);
  // R2
  alloc_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_valid_i && !full_o |=> valid_vec[$past(alloc_id_o)]);

  // R3
  victim_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repl_valid_i && repl_hit_o |-> excl_vec[match_idx] && !repl_writable_i);

  // R5
  absent_marked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upg_valid_i && !upg_present_i |-> repl_vec[upg_id_i]);

  // R5
  reissue_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upg_valid_i && !upg_present_i && dirty_vec[upg_id_i]
    |=> reissue_valid_o && reissue_id_o == $past(upg_id_i) && valid_vec[reissue_id_o]);

  // R6
  fill_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xresp_valid_o && !xresp_last_o |=> xresp_valid_o && xresp_beat_o == $past(xresp_beat_o) + 3'd1);

  // R6
  fill_saved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xresp_valid_o |-> bufv_vec[xresp_id_o] && valid_vec[xresp_id_o]);

  // R6
  fill_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xresp_valid_o && xresp_last_o |=> !valid_vec[$past(xresp_id_o)]);

  // R7
  present_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upg_valid_i && upg_present_i |=> !valid_vec[$past(upg_id_i)] && !reissue_valid_o);

  // R9
  done_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_i |=> !valid_vec[$past(done_id_i)]);
endmodule

bind mshr_file mshr_file_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .alloc_valid_i   (alloc_valid_i),
  .alloc_id_o      (alloc_id_o),
  .full_o          (full_o),
  .repl_valid_i    (repl_valid_i),
  .repl_writable_i (repl_writable_i),
  .repl_hit_o      (repl_hit_o),
  .upg_valid_i     (upg_valid_i),
  .upg_id_i        (upg_id_i),
  .upg_present_i   (upg_present_i),
  .done_valid_i    (done_valid_i),
  .done_id_i       (done_id_i),
  .reissue_valid_o (reissue_valid_o),
  .reissue_id_o    (reissue_id_o),
  .xresp_valid_o   (xresp_valid_o),
  .xresp_id_o      (xresp_id_o),
  .xresp_beat_o    (xresp_beat_o),
  .xresp_last_o    (xresp_last_o),
  .valid_vec       (ent_valid),
  .excl_vec        (ent_excl),
  .repl_vec        (ent_repl),
  .dirty_vec       (ent_dirty),
  .bufv_vec        (ent_bufv),
  .match_idx       (match_idx)
);

// File: tb/mshr_file_tb.sv
module mshr_file_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        alloc_valid_i = 1'b0;
  logic [31:0] alloc_addr_i = '0;
  logic        alloc_excl_i = 1'b0;
  logic [1:0]  alloc_id_o;
  logic        full_o;
  logic        repl_valid_i = 1'b0;
  logic [31:0] repl_addr_i = '0;
  logic        repl_dirty_i = 1'b0;
  logic        repl_writable_i = 1'b0;
  logic [63:0] repl_data_i = '0;
  logic        repl_hit_o;
  logic        upg_valid_i = 1'b0;
  logic [1:0]  upg_id_i = '0;
  logic        upg_present_i = 1'b0;
  logic        done_valid_i = 1'b0;
  logic [1:0]  done_id_i = '0;
  logic        reissue_valid_o;
  logic [1:0]  reissue_id_o;
  logic [31:0] reissue_addr_o;
  logic        xresp_valid_o;
  logic [1:0]  xresp_id_o;
  logic [2:0]  xresp_beat_o;
  logic        xresp_last_o;
  logic [31:0] xresp_addr_o;
  logic [63:0] xresp_data_o;

  always #10 clk = ~clk;

  mshr_file u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid_i), .alloc_addr_i(alloc_addr_i), .alloc_excl_i(alloc_excl_i),
    .alloc_id_o(alloc_id_o), .full_o(full_o),
    .repl_valid_i(repl_valid_i), .repl_addr_i(repl_addr_i), .repl_dirty_i(repl_dirty_i),
    .repl_writable_i(repl_writable_i), .repl_data_i(repl_data_i), .repl_hit_o(repl_hit_o),
    .upg_valid_i(upg_valid_i), .upg_id_i(upg_id_i), .upg_present_i(upg_present_i),
    .done_valid_i(done_valid_i), .done_id_i(done_id_i),
    .reissue_valid_o(reissue_valid_o), .reissue_id_o(reissue_id_o), .reissue_addr_o(reissue_addr_o),
    .xresp_valid_o(xresp_valid_o), .xresp_id_o(xresp_id_o), .xresp_beat_o(xresp_beat_o),
    .xresp_last_o(xresp_last_o), .xresp_addr_o(xresp_addr_o), .xresp_data_o(xresp_data_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  // behavioural model
  bit          m_valid [4];
  logic [31:0] m_addr  [4];
  bit          m_excl  [4];
  bit          m_repl  [4];
  bit          m_dirty [4];
  logic [63:0] m_buf   [4][8];
  int          m_rbeat = 0;
  bit          m_reiss = 0;
  int          m_reiss_id = 0;
  bit          m_fill = 0;
  int          m_fid = 0;
  int          m_fbeat = 0;

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic int low_free();
    for (int i = 3; i >= 0; i--) if (!m_valid[i]) low_free = i;
    if (m_valid[0] && m_valid[1] && m_valid[2] && m_valid[3]) low_free = 0;
  endfunction

  function automatic int find_match(logic [31:0] a);
    find_match = -1;
    for (int i = 3; i >= 0; i--)
      if (m_valid[i] && m_addr[i] == {a[31:6], 6'd0}) find_match = i;
  endfunction

  task automatic compare();
    bit full_e;
    int mi;
    full_e = m_valid[0] && m_valid[1] && m_valid[2] && m_valid[3];
    mi = find_match(repl_addr_i);
    chk("R2", "full_o", 64'(full_o), 64'(full_e));
    chk("R2", "alloc_id_o", 64'(alloc_id_o), 64'(low_free()));
    chk("R3", "repl_hit_o", 64'(repl_hit_o), 64'(repl_valid_i && mi >= 0));
    chk("R5", "reissue_valid_o", 64'(reissue_valid_o), 64'(m_reiss));
    if (m_reiss) begin
      chk("R5", "reissue_id_o", 64'(reissue_id_o), 64'(m_reiss_id));
      chk("R5", "reissue_addr_o", 64'(reissue_addr_o), 64'(m_addr[m_reiss_id]));
    end
    chk("R6", "xresp_valid_o", 64'(xresp_valid_o), 64'(m_fill));
    if (m_fill) begin
      chk("R6", "xresp_id_o", 64'(xresp_id_o), 64'(m_fid));
      chk("R6", "xresp_beat_o", 64'(xresp_beat_o), 64'(m_fbeat));
      chk("R6", "xresp_last_o", 64'(xresp_last_o), 64'(m_fbeat == 7));
      chk("R6", "xresp_addr_o", 64'(xresp_addr_o), 64'(m_addr[m_fid]));
      chk("R6", "xresp_data_o", xresp_data_o, m_buf[m_fid][m_fbeat]);
    end
  endtask

  task automatic advance_model();
    int mi, fi;
    bit any_free;
    any_free = !(m_valid[0] && m_valid[1] && m_valid[2] && m_valid[3]);
    fi = low_free();
    mi = find_match(repl_addr_i);
    m_reiss = 0;
    if (m_fill) begin
      if (m_fbeat == 7) begin
        m_valid[m_fid] = 0;
        m_fill = 0;
      end
      m_fbeat++;
    end
    if (repl_valid_i) begin
      if (mi >= 0 && m_excl[mi] && !repl_writable_i) begin
        if (m_rbeat == 0) begin
          m_repl[mi] = 1;
          m_dirty[mi] = repl_dirty_i;
        end
        if (!repl_dirty_i) m_buf[mi][m_rbeat] = repl_data_i;
      end
      m_rbeat = (m_rbeat + 1) % 8;
    end
    if (upg_valid_i) begin
      if (upg_present_i) m_valid[upg_id_i] = 0;
      else begin
        m_repl[upg_id_i] = 0;
        if (m_dirty[upg_id_i]) begin
          m_reiss = 1;
          m_reiss_id = upg_id_i;
        end else if (!m_fill) begin
          m_fill = 1;
          m_fid = upg_id_i;
          m_fbeat = 0;
        end
      end
    end
    if (done_valid_i) m_valid[done_id_i] = 0;
    if (alloc_valid_i && any_free) begin
      m_valid[fi] = 1;
      m_addr[fi] = {alloc_addr_i[31:6], 6'd0};
      m_excl[fi] = alloc_excl_i;
      m_repl[fi] = 0;
      m_dirty[fi] = 0;
    end
  endtask

  // inputs are set just after a falling edge; sample 5 ns later
  task automatic cyc();
    #5;
    compare();
    advance_model();
    @(negedge clk);
    alloc_valid_i = 0; repl_valid_i = 0; upg_valid_i = 0; done_valid_i = 0;
    repl_dirty_i = 0; repl_writable_i = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic do_alloc(logic [31:0] a, bit ex);
    alloc_valid_i = 1; alloc_addr_i = a; alloc_excl_i = ex;
    cyc();
  endtask

  task automatic do_repl(logic [31:0] a, bit dirty, logic [63:0] base);
    for (int b = 0; b < 8; b++) begin
      repl_valid_i = 1; repl_addr_i = a; repl_dirty_i = dirty;
      repl_data_i = base + 64'(b * 64'h0101);
      cyc();
    end
  endtask

  task automatic do_upg(int id, bit present);
    upg_valid_i = 1; upg_id_i = 2'(id); upg_present_i = present;
    cyc();
  endtask

  task automatic do_done(int id);
    done_valid_i = 1; done_id_i = 2'(id);
    cyc();
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_valid[i] = 0; m_addr[i] = '0; m_excl[i] = 0; m_repl[i] = 0; m_dirty[i] = 0;
    end
    @(negedge clk);
    #2;
    // R1 during reset
    chk("R1", "full_o", 64'(full_o), 64'd0);
    chk("R1", "alloc_id_o", 64'(alloc_id_o), 64'd0);
    chk("R1", "reissue_valid_o", 64'(reissue_valid_o), 64'd0);
    chk("R1", "xresp_valid_o", 64'(xresp_valid_o), 64'd0);
    @(negedge clk);
    rst_ni = 1;
    idle(2);

    // R2: fill all four entries in order
    do_alloc(32'h0000_1000, 1);
    do_alloc(32'h0000_2040, 1);
    do_alloc(32'h0000_3000, 0);
    do_alloc(32'h0000_4000, 1);
    #1 chk("R2", "full after four", 64'(full_o), 64'd1);
    do_alloc(32'h0000_7000, 1);
    #1 chk("R2", "alloc while full ignored", 64'(full_o), 64'd1);

    // R4: victim that matches nothing
    do_repl(32'h0000_9000, 0, 64'hDEAD_0000_0000_0000);
    #1 chk("R4", "no entry change", 64'(full_o), 64'd1);
    chk("R4", "no output", 64'(reissue_valid_o | xresp_valid_o), 64'd0);

    // R6: clean victim of entry 0, then line-absent answer
    do_repl(32'h0000_1010, 0, 64'h1111_2222_3333_0000);
    do_upg(0, 0);
    idle(9);
    #1 chk("R6", "entry freed after stream", 64'(alloc_id_o), 64'd0);
    chk("R6", "not full after stream", 64'(full_o), 64'd0);

    // R5: dirty victim of entry 1
    do_repl(32'h0000_2040, 1, 64'h5555_0000_0000_0000);
    do_upg(1, 0);
    #1 chk("R5", "reissue raised", 64'(reissue_valid_o), 64'd1);
    idle(2);
    do_alloc(32'h0000_5000, 1);
    #1 chk("R5", "reissued entry kept", 64'(full_o), 64'd1);

    // R9
    do_done(1);
    #1 chk("R9", "done frees entry", 64'(alloc_id_o), 64'd1);

    // R7
    do_upg(3, 1);
    idle(2);
    do_alloc(32'h0000_6000, 1);
    #1 chk("R7", "present answer frees entry", 64'(alloc_id_o), 64'd3);
    chk("R7", "no follow-up output", 64'(reissue_valid_o | xresp_valid_o), 64'd0);

    // R8: saved clean line, free, reuse, dirty victim -> reissue not stream
    do_repl(32'h0000_5000, 0, 64'h7777_0000_0000_0000);
    do_done(0);
    do_alloc(32'h0000_5000, 1);
    do_repl(32'h0000_5000, 1, 64'h8888_0000_0000_0000);
    do_upg(0, 0);
    #1 chk("R8", "reissue after reuse", 64'(reissue_valid_o), 64'd1);
    chk("R8", "no stale stream", 64'(xresp_valid_o), 64'd0);
    idle(3);

    // R8: reuse after a clean mark, then present answer
    do_repl(32'h0000_5000, 0, 64'h9999_0000_0000_0000);
    do_done(0);
    do_alloc(32'h0000_A000, 1);
    do_upg(0, 1);
    idle(2);
    #1 chk("R8", "clean reuse no stream", 64'(xresp_valid_o), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule